// File: doc/BRIEF.md
# Saturating Error-Log and Hour-Meter Updater

This block collects two kinds of field-reliability data for a board-level non-volatile record. The first is a bank of pending error counters that any part of the chip can bump by an arbitrary amount. The second is a running count of active seconds. The persistent copy of the record sits in a small local register file that mirrors the non-volatile memory image. Firmware or a transfer engine fills that file through a byte read/write port and later drains it.

When an update is requested, the block first checks whether there is anything worth logging. If there is, it validates the record's checksum and then folds the pending counts into the stored error bytes. It moves whole elapsed hours into the stored hour count and keeps the leftover seconds running. If any byte changed, it rewrites the checksum.

It finishes with a done pulse, an error flag and a write length. The write length is the number of bytes from offset 0 that must be copied back to the non-volatile memory: it reaches exactly to the highest byte that changed, or is zero when nothing changed. The block does not perform the transfer to non-volatile memory itself.

Top module: `elog_updater`

## Requirements
- R1: Each pending error counter (8 bits, selected by `inc_idx`) adds `inc_amt` on a cycle with `inc_valid` high and saturates at 255 for any increment size.
- R2: Record layout: byte 0 is the length byte, byte 1 the checksum, bytes 2 to 5 the stored error counts for counter indexes 0 to 3, byte 6 the low and byte 7 the high byte of the 16-bit hour count. `buf_rdata` always shows the byte at `buf_addr`; `buf_we` writes `buf_wdata` there on the clock edge.
- R3: A request with all pending counters zero and `active_secs` below 3600 changes nothing: `done` pulses for one cycle two clock edges after the request edge, with `error` 0 and `wr_len` 0. A full update's `done` comes 26 edges after the request when nothing is written and 43 edges after it when a write is needed (default sizes).
- R4: The computed checksum is the bitwise inverse of (8-bit sum of the first min(length byte, record size) bytes minus the stored checksum byte). If it differs from the stored checksum, the update aborts: `error` is 1, `wr_len` is 0, `done` comes 19 edges after the request, the record is unchanged and the pending counters are kept.
- R5: On a valid record, each error byte with a nonzero pending count becomes stored plus pending, saturated at 0xFF, and that pending counter is cleared.
- R6: When `active_secs` exceeds 3600, the whole hours (seconds / 3600) are added to the stored hour count, saturating at 0xFFFF. The hours times 3600 are subtracted from `active_secs`, which keeps the remainder.
- R7: With exactly 3600 seconds and nothing pending, the update runs but transfers no hour, so `wr_len` is 0, `error` is 0 and `active_secs` stays 3600.
- R8: `wr_len` is one plus the offset of the highest byte whose value actually changed. It is 0 when no byte changed, including when a pending count lands on a byte already at 0xFF.
- R9: When `wr_len` is nonzero, byte 1 holds the checksum recomputed over the updated record by the R4 rule before `done` is raised.
- R10: While `busy` is high, `buf_we` and `upd_req` are ignored.
- R11: `active_secs` counts one per cycle with `sec_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-second strobe |
| inc_valid | input | 1 | Error increment strobe |
| inc_idx | input | 2 | Error counter index |
| inc_amt | input | 16 | Increment amount |
| upd_req | input | 1 | Start an update |
| buf_we | input | 1 | Record byte write enable |
| buf_addr | input | 4 | Record byte address |
| buf_wdata | input | 8 | Record write data |
| buf_rdata | output | 8 | Record read data |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle end-of-update pulse |
| error | output | 1 | Checksum mismatch on last update |
| wr_len | output | 5 | Bytes from offset 0 needing write-back |
| active_secs | output | 24 | Running active-seconds count |

## Verification
Each result has a fixed due time counted in clock edges from the edge that samples `upd_req`. The no-op answer is due after 2 edges and the checksum abort after 19. A full pass is due after 26 edges, or after 43 when the checksum is rewritten. The bench counts the edges until `done` is seen and compares that count to the due figure, then reads `wr_len`, `error` and `active_secs` half a cycle after that edge. Record bytes are read back through the byte port only after `done`, and R10 is judged by reading back a byte that was targeted while the block was busy.

// File: rtl/elog_pkg.sv
package elog_pkg;

    localparam int unsigned SECS_PER_HOUR = 3600;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CHECK,
        ST_ERR,
        ST_HCALC,
        ST_HLO,
        ST_HHI,
        ST_CKWR,
        ST_FIN
    } elog_state_e;

endpackage

// File: rtl/elog_pending.sv
module elog_pending #(
    parameter int NUM_ERR = 4,
    parameter int INC_W   = 16,
    parameter int IDX_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc_valid,
    input  logic [IDX_W-1:0]        inc_idx,
    input  logic [INC_W-1:0]        inc_amt,
    input  logic [NUM_ERR-1:0]      clr,
    output logic [NUM_ERR-1:0][7:0] pend
);

    localparam int SUM_W = ((INC_W > 8) ? INC_W : 8) + 1;

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
        logic [7:0]       cnt_q;
        logic [7:0]       cnt_d;
        logic [7:0]       base;
        logic [SUM_W-1:0] sum;

        always_comb begin
            base  = clr[g] ? 8'h00 : cnt_q;
            sum   = SUM_W'(base) + SUM_W'(inc_amt);
            cnt_d = base;
            if (inc_valid && (inc_idx == IDX_W'(g))) begin
                cnt_d = (sum > SUM_W'(255)) ? 8'hFF : sum[7:0];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= 8'h00;
            else        cnt_q <= cnt_d;
        end

        assign pend[g] = cnt_q;

        // R1: a full counter stays full under further increments
        p_sat_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_valid && inc_idx == IDX_W'(g) && cnt_q == 8'hFF && !clr[g])
            |=> (cnt_q == 8'hFF));
    end

endmodule

// File: rtl/elog_secs.sv
module elog_secs #(
    parameter int SEC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sub_en,
    input  logic [SEC_W-1:0] sub_val,
    output logic [SEC_W-1:0] secs
);

    logic [SEC_W-1:0] secs_q;
    logic [SEC_W-1:0] secs_d;
    logic [SEC_W-1:0] left;

    always_comb begin
        left   = sub_en ? (secs_q - sub_val) : secs_q;
        secs_d = left;
        if (tick && (left != {SEC_W{1'b1}})) secs_d = left + SEC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) secs_q <= '0;
        else        secs_q <= secs_d;
    end

    assign secs = secs_q;

    // R11: one count per strobe when no hours are being withdrawn
    p_tick_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !sub_en && secs_q != {SEC_W{1'b1}})
        |=> (secs_q == $past(secs_q) + SEC_W'(1)));

endmodule

// File: rtl/elog_regfile.sv
module elog_regfile #(
    parameter int BYTES  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [7:0]        ext_wdata,
    output logic [7:0]        ext_rdata,
    input  logic              int_we,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic [7:0]        int_wdata,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [7:0]        rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [7:0]        rd_b_data
);

    logic [7:0] mem_q [BYTES];
    logic [7:0] mem_d [BYTES];

    always_comb begin
        for (int i = 0; i < BYTES; i++) begin
            if (int_we && int'(int_addr) == i)      mem_d[i] = int_wdata;
            else if (ext_we && int'(ext_addr) == i) mem_d[i] = ext_wdata;
            else                                    mem_d[i] = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= 8'h00;
        end else begin
            for (int i = 0; i < BYTES; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign ext_rdata = (int'(ext_addr) < BYTES)  ? mem_q[ext_addr]  : 8'h00;
    assign rd_a_data = (int'(rd_a_addr) < BYTES) ? mem_q[rd_a_addr] : 8'h00;
    assign rd_b_data = (int'(rd_b_addr) < BYTES) ? mem_q[rd_b_addr] : 8'h00;

    // R2: an internal write lands in the addressed byte
    p_int_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_we |=> (mem_q[$past(int_addr)] == $past(int_wdata)));

endmodule

// File: rtl/elog_updater.sv
module elog_updater
    import elog_pkg::*;
#(
    parameter int NUM_ERR   = 4,
    parameter int REC_BYTES = 16,
    parameter int SEC_W     = 24,
    parameter int INC_W     = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sec_tick,
    input  logic                         inc_valid,
    input  logic [$clog2(NUM_ERR)-1:0]   inc_idx,
    input  logic [INC_W-1:0]             inc_amt,
    input  logic                         upd_req,
    input  logic                         buf_we,
    input  logic [$clog2(REC_BYTES)-1:0] buf_addr,
    input  logic [7:0]                   buf_wdata,
    output logic [7:0]                   buf_rdata,
    output logic                         busy,
    output logic                         done,
    output logic                         error,
    output logic [$clog2(REC_BYTES):0]   wr_len,
    output logic [SEC_W-1:0]             active_secs
);

    localparam int ADDR_W  = $clog2(REC_BYTES);
    localparam int IDX_W   = $clog2(NUM_ERR);
    localparam int LEN_W   = ADDR_W + 1;
    localparam int OFF_LEN = 0;
    localparam int OFF_CK  = 1;
    localparam int OFF_ERR = 2;
    localparam int OFF_HLO = OFF_ERR + NUM_ERR;
    localparam int OFF_HHI = OFF_HLO + 1;
    localparam int HW      = ((SEC_W > 16) ? SEC_W : 16) + 1;

    typedef struct packed {
        elog_state_e       st;
        logic [8:0]        idx;
        logic [7:0]        acc;
        logic              resum;
        logic              changed;
        logic [ADDR_W-1:0] mark;
        logic [15:0]       hrs;
        logic              done;
        logic              err;
        logic [LEN_W-1:0]  len;
    } upd_state_t;

    upd_state_t s_q, s_d;

    logic [NUM_ERR-1:0][7:0] pend;
    logic [NUM_ERR-1:0]      clr;
    logic                    sub_en;
    logic [SEC_W-1:0]        sub_val;
    logic                    int_we;
    logic [ADDR_W-1:0]       int_addr;
    logic [7:0]              int_wdata;
    logic [ADDR_W-1:0]       rd_a_addr, rd_b_addr;
    logic [7:0]              rd_a_data, rd_b_data;
    logic                    ext_we;
    logic                    any_pend;
    logic                    trigger;

    assign ext_we = buf_we && (s_q.st == ST_IDLE);

    elog_pending #(.NUM_ERR(NUM_ERR), .INC_W(INC_W), .IDX_W(IDX_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .inc_valid(inc_valid), .inc_idx(inc_idx),
        .inc_amt(inc_amt), .clr(clr), .pend(pend)
    );

    elog_secs #(.SEC_W(SEC_W)) u_secs (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .sub_en(sub_en),
        .sub_val(sub_val), .secs(active_secs)
    );

    elog_regfile #(.BYTES(REC_BYTES), .ADDR_W(ADDR_W)) u_rec (
        .clk(clk), .rst_n(rst_n),
        .ext_we(ext_we), .ext_addr(buf_addr), .ext_wdata(buf_wdata), .ext_rdata(buf_rdata),
        .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    always_comb begin
        any_pend = 1'b0;
        for (int k = 0; k < NUM_ERR; k++) any_pend = any_pend | (pend[k] != 8'h00);
        trigger = any_pend || (active_secs >= SEC_W'(SECS_PER_HOUR));
    end

    always_comb begin
        logic [8:0]       lim;
        logic [8:0]       sum9;
        logic [7:0]       nv;
        logic [7:0]       calc;
        logic [7:0]       p;
        logic [SEC_W-1:0] h;
        logic [HW-1:0]    tot;

        s_d       = s_q;
        s_d.done  = 1'b0;
        clr       = '0;
        sub_en    = 1'b0;
        sub_val   = '0;
        int_we    = 1'b0;
        int_addr  = '0;
        int_wdata = 8'h00;
        rd_a_addr = '0;
        rd_b_addr = ADDR_W'(OFF_LEN);
        lim       = '0;
        sum9      = '0;
        nv        = 8'h00;
        calc      = 8'h00;
        p         = 8'h00;
        h         = '0;
        tot       = '0;

        case (s_q.st)
            ST_IDLE: begin
                if (upd_req) begin
                    s_d.err     = 1'b0;
                    s_d.len     = '0;
                    s_d.idx     = '0;
                    s_d.acc     = 8'h00;
                    s_d.resum   = 1'b0;
                    s_d.changed = 1'b0;
                    s_d.mark    = '0;
                    s_d.st      = trigger ? ST_SCAN : ST_FIN;
                end
            end
            ST_SCAN: begin
                rd_a_addr = s_q.idx[ADDR_W-1:0];
                rd_b_addr = ADDR_W'(OFF_LEN);
                lim = ({1'b0, rd_b_data} > 9'(REC_BYTES)) ? 9'(REC_BYTES) : {1'b0, rd_b_data};
                if (s_q.idx < lim) s_d.acc = s_q.acc + rd_a_data;
                s_d.idx = s_q.idx + 9'd1;
                if (s_q.idx == 9'(REC_BYTES - 1)) begin
                    s_d.st = s_q.resum ? ST_CKWR : ST_CHECK;
                end
            end
            ST_CHECK: begin
                rd_a_addr = ADDR_W'(OFF_CK);
                calc = ~(s_q.acc - rd_a_data);
                if (calc != rd_a_data) begin
                    s_d.err = 1'b1;
                    s_d.st  = ST_FIN;
                end else begin
                    s_d.idx = '0;
                    s_d.st  = ST_ERR;
                end
            end
            ST_ERR: begin
                rd_a_addr = ADDR_W'(OFF_ERR) + s_q.idx[ADDR_W-1:0];
                p = pend[s_q.idx[IDX_W-1:0]];
                if (p != 8'h00) begin
                    clr[s_q.idx[IDX_W-1:0]] = 1'b1;
                    sum9 = {1'b0, rd_a_data} + {1'b0, p};
                    nv   = sum9[8] ? 8'hFF : sum9[7:0];
                    if (nv != rd_a_data) begin
                        int_we      = 1'b1;
                        int_addr    = rd_a_addr;
                        int_wdata   = nv;
                        s_d.changed = 1'b1;
                        s_d.mark    = rd_a_addr;
                    end
                end
                s_d.idx = s_q.idx + 9'd1;
                if (s_q.idx == 9'(NUM_ERR - 1)) s_d.st = ST_HCALC;
            end
            ST_HCALC: begin
                rd_a_addr = ADDR_W'(OFF_HLO);
                rd_b_addr = ADDR_W'(OFF_HHI);
                s_d.hrs   = {rd_b_data, rd_a_data};
                if (active_secs > SEC_W'(SECS_PER_HOUR)) begin
                    h       = active_secs / SEC_W'(SECS_PER_HOUR);
                    sub_en  = 1'b1;
                    sub_val = SEC_W'(h * SEC_W'(SECS_PER_HOUR));
                    tot     = HW'({rd_b_data, rd_a_data}) + HW'(h);
                    s_d.hrs = (tot > HW'(16'hFFFF)) ? 16'hFFFF : tot[15:0];
                end
                s_d.st = ST_HLO;
            end
            ST_HLO: begin
                rd_a_addr = ADDR_W'(OFF_HLO);
                if (s_q.hrs[7:0] != rd_a_data) begin
                    int_we      = 1'b1;
                    int_addr    = rd_a_addr;
                    int_wdata   = s_q.hrs[7:0];
                    s_d.changed = 1'b1;
                    s_d.mark    = rd_a_addr;
                end
                s_d.st = ST_HHI;
            end
            ST_HHI: begin
                rd_a_addr = ADDR_W'(OFF_HHI);
                if (s_q.hrs[15:8] != rd_a_data) begin
                    int_we      = 1'b1;
                    int_addr    = rd_a_addr;
                    int_wdata   = s_q.hrs[15:8];
                    s_d.changed = 1'b1;
                    s_d.mark    = rd_a_addr;
                end
                if (s_d.changed) begin
                    s_d.resum = 1'b1;
                    s_d.idx   = '0;
                    s_d.acc   = 8'h00;
                    s_d.st    = ST_SCAN;
                end else begin
                    s_d.st = ST_FIN;
                end
            end
            ST_CKWR: begin
                rd_a_addr = ADDR_W'(OFF_CK);
                int_we    = 1'b1;
                int_addr  = ADDR_W'(OFF_CK);
                int_wdata = ~(s_q.acc - rd_a_data);
                s_d.len   = LEN_W'({1'b0, s_q.mark}) + LEN_W'(1);
                s_d.st    = ST_FIN;
            end
            ST_FIN: begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy   = (s_q.st != ST_IDLE);
    assign done   = s_q.done;
    assign error  = s_q.err;
    assign wr_len = s_q.len;

    // R3: nothing to log gives an empty result two edges later
    p_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && upd_req && !trigger)
        |-> ##2 (done && !error && wr_len == '0));

    // R3: done is a single-cycle pulse
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: an aborted update never asks for a write
    p_err_nolen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (wr_len == '0));

    // R6: after an hour transfer only the remainder (plus one strobe) is left
    p_rem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HCALC && active_secs > SEC_W'(SECS_PER_HOUR))
        |=> (active_secs <= SEC_W'(SECS_PER_HOUR)));

endmodule

// File: tb/elog_updater_tb.sv
module elog_updater_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        inc_valid = 1'b0;
    logic [1:0]  inc_idx = '0;
    logic [15:0] inc_amt = '0;
    logic        upd_req = 1'b0;
    logic        buf_we = 1'b0;
    logic [3:0]  buf_addr = '0;
    logic [7:0]  buf_wdata = '0;
    logic [7:0]  buf_rdata;
    logic        busy, done, error;
    logic [4:0]  wr_len;
    logic [23:0] active_secs;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_mem [16];

    always #5 clk = ~clk;

    elog_updater u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .inc_valid(inc_valid),
        .inc_idx(inc_idx), .inc_amt(inc_amt), .upd_req(upd_req), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .busy(busy), .done(done), .error(error), .wr_len(wr_len),
        .active_secs(active_secs)
    );

    task automatic chk(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] ck_calc();
        logic [7:0] s = 8'h00;
        int lim = (exp_mem[0] > 16) ? 16 : int'(exp_mem[0]);
        for (int i = 0; i < lim; i++) s = s + exp_mem[i];
        return ~(s - exp_mem[1]);
    endfunction

    task automatic wr_byte(input int a, input logic [7:0] d);
        @(negedge clk);
        buf_we = 1'b1; buf_addr = 4'(a); buf_wdata = d;
        @(posedge clk);
        @(negedge clk);
        buf_we = 1'b0;
        exp_mem[a] = d;
    endtask

    task automatic rd_byte(input int a, output logic [7:0] d);
        @(negedge clk);
        buf_addr = 4'(a);
        #1 d = buf_rdata;
    endtask

    task automatic fix_ck();
        wr_byte(1, ck_calc());
    endtask

    task automatic check_rec(input string tag);
        logic [7:0] d;
        for (int i = 0; i < 16; i++) begin
            rd_byte(i, d);
            chk($sformatf("%s byte%0d", tag, i), d, exp_mem[i]);
        end
    endtask

    task automatic inc(input int idx, input int amt);
        @(negedge clk);
        inc_valid = 1'b1; inc_idx = 2'(idx); inc_amt = 16'(amt);
        @(posedge clk);
        @(negedge clk);
        inc_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        sec_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic do_update(output int n);
        @(negedge clk);
        upd_req = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        upd_req = 1'b0;
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R3 reset busy", busy, 0);
        chk("R3 reset done", done, 0);
        chk("R3 reset error", error, 0);
        chk("R3 reset wr_len", wr_len, 0);
        chk("R11 reset secs", active_secs, 0);
    endtask

    task automatic t_load();
        wr_byte(0, 8'h40);
        wr_byte(2, 8'h10); wr_byte(3, 8'h00); wr_byte(4, 8'hFE); wr_byte(5, 8'h20);
        wr_byte(6, 8'hFE); wr_byte(7, 8'h12);
        for (int i = 8; i < 16; i++) wr_byte(i, 8'(8'hA0 + i));
        fix_ck();
        check_rec("R2 load");
    endtask

    task automatic t_noop();
        int n;
        do_update(n);
        chk("R3 noop latency", n, 2);
        chk("R3 noop error", error, 0);
        chk("R3 noop wr_len", wr_len, 0);
    endtask

    task automatic t_bad_ck();
        int n;
        logic [7:0] good = exp_mem[1];
        wr_byte(1, good ^ 8'h01);
        inc(0, 5);
        do_update(n);
        chk("R4 abort latency", n, 19);
        chk("R4 abort error", error, 1);
        chk("R4 abort wr_len", wr_len, 0);
        check_rec("R4 untouched");
        wr_byte(1, good);
    endtask

    task automatic t_merge();
        int n;
        inc(1, 200);
        inc(1, 100);
        inc(2, 10);
        do_update(n);
        exp_mem[2] = 8'h15;
        exp_mem[3] = 8'hFF;
        exp_mem[4] = 8'hFF;
        exp_mem[1] = ck_calc();
        chk("R3 write latency", n, 43);
        chk("R5 merge error", error, 0);
        chk("R8 merge wr_len", wr_len, 5);
        check_rec("R5 R1 R9 merge");
    endtask

    task automatic t_nochange();
        int n;
        inc(2, 1);
        do_update(n);
        chk("R3 nowrite latency", n, 26);
        chk("R8 nochange wr_len", wr_len, 0);
        chk("R8 nochange error", error, 0);
        check_rec("R8 nochange");
        do_update(n);
        chk("R5 pending cleared", n, 2);
    endtask

    task automatic t_hours();
        int n;
        ticks(7205);
        chk("R11 tick count", active_secs, 7205);
        do_update(n);
        exp_mem[6] = 8'h00;
        exp_mem[7] = 8'h13;
        exp_mem[1] = ck_calc();
        chk("R6 carry wr_len", wr_len, 8);
        chk("R6 remainder", active_secs, 5);
        check_rec("R6 carry");
    endtask

    task automatic t_exact();
        int n;
        ticks(3595);
        do_update(n);
        chk("R7 exact latency", n, 26);
        chk("R7 exact wr_len", wr_len, 0);
        chk("R7 exact error", error, 0);
        chk("R7 exact secs", active_secs, 3600);
        ticks(1);
        do_update(n);
        exp_mem[6] = 8'h01;
        exp_mem[1] = ck_calc();
        chk("R6 one hour wr_len", wr_len, 7);
        chk("R6 one hour secs", active_secs, 1);
        check_rec("R6 one hour");
    endtask

    task automatic t_hour_sat();
        int n;
        wr_byte(6, 8'hFE);
        wr_byte(7, 8'hFF);
        fix_ck();
        ticks(7200);
        do_update(n);
        exp_mem[6] = 8'hFF;
        exp_mem[1] = ck_calc();
        chk("R6 sat wr_len", wr_len, 7);
        chk("R6 sat secs", active_secs, 1);
        check_rec("R6 sat");
    endtask

    task automatic t_short_len();
        int n;
        wr_byte(0, 8'h03);
        fix_ck();
        inc(0, 1);
        do_update(n);
        exp_mem[2] = 8'h16;
        exp_mem[1] = ck_calc();
        chk("R4 short len error", error, 0);
        chk("R8 short len wr_len", wr_len, 3);
        check_rec("R9 short len");
    endtask

    task automatic t_busy();
        int n;
        logic [7:0] d;
        inc(3, 1);
        @(negedge clk);
        upd_req = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        upd_req = 1'b1;
        buf_we = 1'b1; buf_addr = 4'd9; buf_wdata = 8'h55;
        @(posedge clk);
        n++;
        @(negedge clk);
        upd_req = 1'b0;
        buf_we = 1'b0;
        while (!done && n < 200) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk("R10 busy update latency", n, 43);
        chk("R10 busy wr_len", wr_len, 6);
        @(negedge clk);
        chk("R10 second request ignored", busy, 0);
        exp_mem[5] = 8'h21;
        rd_byte(9, d);
        chk("R10 write ignored", d, exp_mem[9]);
        rd_byte(5, d);
        chk("R5 busy merge", d, 8'h21);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_load();
        t_noop();
        t_bad_ck();
        t_merge();
        t_nochange();
        t_hours();
        t_exact();
        t_hour_sat();
        t_short_len();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule